// File: doc/BRIEF.md
# Phase-Frequency Comparator with Lock Indicator

This block compares two divided pulse streams, the main-divider output and the reference-divider output, and turns their relative timing into two active-low correction pulses. When the main stream's edge arrives first, the "down" correction goes low; when the reference edge arrives first, the "up" correction goes low. Each goes low on its own rising edge. Once both edges have been seen, both outputs are cleared together one cycle later. Because of this fixed clearing delay, even perfectly aligned edges give a one-cycle pulse on both outputs. The loop therefore has no dead zone around zero phase error.

Both inputs are sampled by the block clock, which must run much faster than either stream. A phase error is thus resolved in whole clock cycles. The two correction outputs are merged into an activity signal, the NAND of the two active-low outputs. A lock detector measures how long each burst of activity lasts. It declares lock after a programmable run of consecutive comparisons whose activity is short, which stands in for the charge time of an external filter capacitor. A single long burst removes lock at once. The lock result also appears as an open-drain style pull-low request, which is released while the loop is locked. The pulse inputs are plain level signals sampled every cycle. They carry no data, so there is no valid/ready handshake and no back-pressure: each input must simply stay high for at least one clock cycle per edge.

Top module: `pfd_lock_top`

## Requirements
- R1: During and directly after reset, `up_n` and `dn_n` are 1, `activity` is 0, `locked` is 0 and `lk_pull_low` is 1.
- R2: When `main_in` rises D cycles (D ≥ 1) before `ref_in`, `dn_n` is low for D+1 consecutive cycles, starting the cycle after the `main_in` rise is sampled, and `up_n` is low for exactly 1 cycle, the last of those.
- R3: When `ref_in` rises D cycles (D ≥ 1) before `main_in`, `up_n` is low for D+1 cycles and `dn_n` is low for exactly 1 cycle, mirroring R2.
- R4: When both inputs rise in the same sampled cycle, `up_n` and `dn_n` are both low for exactly one cycle, and both are then cleared together.
- R5: `activity` is 1 exactly when at least one of `up_n` and `dn_n` is 0, that is, `activity` is the NAND of `up_n` and `dn_n`.
- R6: A comparison is good when its activity burst lasts at most SKEW_LIMIT cycles (default 2). `locked` goes to 1 at the clock edge that ends the LOCK_RUNS-th consecutive good comparison (default 4). It then stays 1 while comparisons remain good.
- R7: Once a burst of activity exceeds SKEW_LIMIT cycles, `locked` is 0 from the next clock edge on, and the run of good comparisons restarts from zero.
- R8: `lk_pull_low` is always the inverse of `locked`: it is released (0) when locked and requests a low drive (1) otherwise.
- R9: A single long comparison inside a run of good ones discards the run. LOCK_RUNS-1 good comparisons after it leave `locked` at 0, and the next good one sets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, much faster than either pulse stream |
| rst_n | input | 1 | Synchronous active-low reset |
| main_in | input | 1 | Main-divider pulse stream; its rising edge is compared |
| ref_in | input | 1 | Reference-divider pulse stream; its rising edge is compared |
| up_n | output | 1 | Active-low up correction; low while the reference leads |
| dn_n | output | 1 | Active-low down correction; low while the main stream leads |
| activity | output | 1 | NAND of `up_n` and `dn_n` |
| locked | output | 1 | Lock flag |
| lk_pull_low | output | 1 | Pull-low request for an open-drain lock pin; 0 means released |

## Verification
An input rise sampled at clock edge k takes effect on the correction outputs after edge k. When the lagging edge is sampled at edge k+D, both outputs clear at edge k+D+1. Activity therefore spans exactly the D+1 cycles in between. `locked` changes at the same edge that ends the deciding burst; for a long burst, it changes at the edge that ends the first over-limit cycle. The bench drives its inputs on falling edges and samples every output on falling edges. A driver task pushes the expected pulse widths and the expected lock state for each comparison into a scoreboard. A monitor counts the low cycles of each output and compares them with the scoreboard once activity has fallen, which is the first sample at which all three results of a comparison are final.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // channel order on the sampled pulse vector
  localparam int CH_MAIN = 0;
  localparam int CH_REF  = 1;
  localparam int N_CH    = 2;

  typedef struct packed {
    logic up;   // reference leads
    logic dn;   // main stream leads
  } corr_t;
endpackage

// File: rtl/pfd_edge.sv
module pfd_edge #(
  parameter int CHANNELS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] lvl,
  output logic [CHANNELS-1:0] rise
);
  logic [CHANNELS-1:0] lvl_q;

  for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) lvl_q[g] <= 1'b0;
      else        lvl_q[g] <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~lvl_q[g];
  end
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] rise,
  output corr_t           corr
);
  logic up_ff, dn_ff, both;

  assign both = up_ff & dn_ff;

  // each flop sets on its own edge; both clear one cycle after both are set
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_ff <= 1'b0;
      dn_ff <= 1'b0;
    end else begin
      up_ff <= rise[CH_REF]  | (up_ff & ~both);
      dn_ff <= rise[CH_MAIN] | (dn_ff & ~both);
    end
  end

  assign corr.up = up_ff;
  assign corr.dn = dn_ff;

  AST_DN_FROM_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_ff) |-> $past(rise[CH_MAIN])); // R2
  AST_UP_FROM_REF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_ff) |-> $past(rise[CH_REF])); // R3
  AST_CLEAR_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ff && dn_ff && !rise[CH_MAIN] && !rise[CH_REF]) |=> (!up_ff && !dn_ff)); // R4
endmodule

// File: rtl/pfd_lockdet.sv
module pfd_lockdet #(
  parameter int SKEW_LIMIT = 2,
  parameter int LOCK_RUNS  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic cmp_end,
  output logic locked
);
  localparam int RUN_W = $clog2(SKEW_LIMIT + 2);
  localparam int CNT_W = $clog2(LOCK_RUNS + 1);
  localparam logic [RUN_W-1:0] LIM  = RUN_W'(SKEW_LIMIT);
  localparam logic [RUN_W-1:0] SAT  = RUN_W'(SKEW_LIMIT + 1);
  localparam logic [CNT_W-1:0] RUNS = CNT_W'(LOCK_RUNS);

  logic [RUN_W-1:0] run_len, cur_len;
  logic [CNT_W-1:0] good_cnt;
  logic             wide;

  // length of the current burst including this cycle, saturating
  assign cur_len = (run_len == SAT) ? run_len : run_len + 1'b1;
  assign wide    = act && (cur_len > LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) run_len <= '0;
    else        run_len <= act ? cur_len : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      good_cnt <= '0;
      locked   <= 1'b0;
    end else if (wide) begin
      good_cnt <= '0;
      locked   <= 1'b0;
    end else if (cmp_end) begin
      if (good_cnt != RUNS) good_cnt <= good_cnt + 1'b1;
      if (good_cnt + 1'b1 >= RUNS) locked <= 1'b1;
    end
  end

  AST_WIDE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    wide |=> !locked); // R7
  AST_LOCK_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(cmp_end)); // R6
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !wide) |=> locked); // R6
  AST_NO_LOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !cmp_end) |=> !locked); // R9
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_pkg::*;
#(
  parameter int SKEW_LIMIT = 2,
  parameter int LOCK_RUNS  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic main_in,
  input  logic ref_in,
  output logic up_n,
  output logic dn_n,
  output logic activity,
  output logic locked,
  output logic lk_pull_low
);
  logic [N_CH-1:0] lvl, rise;
  corr_t           corr;

  assign lvl[CH_MAIN] = main_in;
  assign lvl[CH_REF]  = ref_in;

  pfd_edge #(.CHANNELS(N_CH)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise)
  );

  pfd_core u_core (
    .clk(clk), .rst_n(rst_n), .rise(rise), .corr(corr)
  );

  assign up_n     = ~corr.up;
  assign dn_n     = ~corr.dn;
  assign activity = ~(up_n & dn_n);

  pfd_lockdet #(.SKEW_LIMIT(SKEW_LIMIT), .LOCK_RUNS(LOCK_RUNS)) u_lock (
    .clk(clk), .rst_n(rst_n), .act(activity),
    .cmp_end(corr.up & corr.dn), .locked(locked)
  );

  assign lk_pull_low = ~locked;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (up_n && dn_n && !locked)); // R1
endmodule

// File: tb/tb_pfd_lock_top.sv
module tb_pfd_lock_top;
  localparam int CLK_PERIOD = 10;
  localparam int SKEW_LIMIT = 2;
  localparam int LOCK_RUNS  = 4;

  logic clk = 1'b0, rst_n = 1'b0, main_in = 1'b0, ref_in = 1'b0;
  logic up_n, dn_n, activity, locked, lk_pull_low;

  pfd_lock_top #(.SKEW_LIMIT(SKEW_LIMIT), .LOCK_RUNS(LOCK_RUNS)) dut (
    .clk(clk), .rst_n(rst_n), .main_in(main_in), .ref_in(ref_in),
    .up_n(up_n), .dn_n(dn_n), .activity(activity),
    .locked(locked), .lk_pull_low(lk_pull_low)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    q_up[$], q_dn[$], q_lk[$];
  string q_tag[$];
  int    total = 0, bad = 0, streak = 0;
  bit    done = 1'b0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // lead: 0 = main first, 1 = ref first, 2 = together; d = skew in cycles
  task automatic compare(int lead, int d, string tag);
    int w;
    w = (lead == 2) ? 1 : d + 1;
    if (w <= SKEW_LIMIT) streak++; else streak = 0;
    q_up.push_back((lead == 1) ? w : 1);
    q_dn.push_back((lead == 0) ? w : 1);
    q_lk.push_back((streak >= LOCK_RUNS) ? 1 : 0);
    q_tag.push_back(tag);
    @(negedge clk);
    if (lead != 1) main_in = 1'b1;
    if (lead != 0) ref_in  = 1'b1;
    if (lead != 2) begin
      for (int i = 1; i <= d; i++) begin
        @(negedge clk);
        if (i == 1) begin main_in = 1'b0; ref_in = 1'b0; end
      end
      if (lead == 0) ref_in = 1'b1; else main_in = 1'b1;
    end
    @(negedge clk);
    main_in = 1'b0;
    ref_in  = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // monitor: measure each burst and compare with the scoreboard
  int cnt_up = 0, cnt_dn = 0;
  bit was_act = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(activity == !(up_n && dn_n), "R5", "activity", activity, !(up_n && dn_n));
      chk(lk_pull_low == !locked, "R8", "lk_pull_low", lk_pull_low, !locked);
      if (!up_n) cnt_up++;
      if (!dn_n) cnt_dn++;
      if (was_act && !activity) begin
        if (q_up.size() == 0) begin
          chk(1'b0, "R5", "unexpected burst", 1, 0);
        end else begin
          string t;
          int eu, ed, el;
          eu = q_up.pop_front(); ed = q_dn.pop_front();
          el = q_lk.pop_front(); t = q_tag.pop_front();
          chk(cnt_up == eu, t, "up_n low cycles", cnt_up, eu);
          chk(cnt_dn == ed, t, "dn_n low cycles", cnt_dn, ed);
          chk(int'(locked) == el, t, "locked", locked, el);
        end
        cnt_up = 0;
        cnt_dn = 0;
      end
      was_act = activity;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(up_n == 1'b1 && dn_n == 1'b1, "R1", "corrections in reset", {up_n, dn_n}, 3);
    chk(activity == 1'b0 && locked == 1'b0, "R1", "activity/locked in reset", {activity, locked}, 0);
    chk(lk_pull_low == 1'b1, "R1", "pull-low in reset", lk_pull_low, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(up_n && dn_n && !activity && !locked, "R1", "after reset", {up_n, dn_n, activity, locked}, 12);

    // R4 aligned edges, lock after LOCK_RUNS good comparisons (R6)
    for (int i = 0; i < LOCK_RUNS; i++) compare(2, 0, (i == LOCK_RUNS-1) ? "R6" : "R4");
    compare(0, 1, "R2");          // main leads, short: stays locked
    compare(1, 1, "R3");          // ref leads, short
    compare(0, 2, "R7");          // wide burst drops lock
    for (int i = 0; i < LOCK_RUNS-1; i++) compare(2, 0, "R9");
    compare(1, 3, "R9");          // wide ref-lead inside run
    for (int i = 0; i < LOCK_RUNS-1; i++) compare(0, 1, "R9");
    compare(2, 0, "R9");          // completes a fresh run: locks
    compare(0, 6, "R7");          // long stall of reference
    compare(1, 5, "R3");
    repeat (10) @(negedge clk);
    chk(q_up.size() == 0, "R6", "scoreboard drained", q_up.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule